// File: doc/BRIEF.md
# DMA Command Instruction Front End

This block sits beside a processor's decode stage. It interprets a small family of custom instructions that program and steer a DMA engine. Each instruction arrives as a full 32-bit word together with the values already read from its two source registers. Configuration instructions load shadow registers: a 64-bit source address, a 64-bit destination address, two strides and a repeat count.

A copy instruction presents a transfer descriptor to the data mover through a valid/ready handshake. When the handshake completes, the copy is given a sequential transfer ID, and that ID is returned on the register writeback path. While the mover refuses the descriptor, the instruction is held back. Status instructions return either a count of finished transfers or a busy indication.

Software waits for transfer `t` by polling the finished count until it is strictly greater than `t`. For that to work, the mover must report completions in issue order, one pulse per transfer.

Top module: `dma_cmd_frontend`

## Requirements
- R1: Only words with major opcode bits [6:0] = 7'b0101011, funct3 bits [14:12] = 3'b000 and funct7 bits [31:25] in {0,1,2,4,6,7} are acted on. Any other word is accepted (ready high), writes no result, raises no descriptor and changes no state.
- R2: funct7 = 0 loads the source address and funct7 = 1 loads the destination address. In both, the first operand supplies bits [31:0] and the second operand supplies bits [63:32].
- R3: funct7 = 6 loads the source stride from the first operand and the destination stride from the second operand.
- R4: funct7 = 7 loads the repeat count from the first operand. The second operand is ignored.
- R5: funct7 = 2 raises a descriptor in the same cycle. Its size is the first operand, and its two-dimensional flag is bit 1 of the rs2 field (instruction bit 21). The descriptor also carries the current addresses, strides and repeat count.
- R6: A copy completes only in a cycle where the descriptor is taken (ready input high). Otherwise instruction ready is low, no result is written, and the ID counter holds.
- R7: Each completed copy writes its transfer ID to the result. IDs start at 0 after reset and rise by one per completed copy.
- R8: funct7 = 4 is a status read selected by the rs2 field (bits [24:20]). Selector 0 returns the number of completion pulses seen so far. Selector 2 returns 1 while issued and completed counts differ, and 0 otherwise. Any other selector returns 0. A completion pulse in the same cycle is counted only from the next cycle on.
- R9: Configuration values persist across copies and across ignored instructions until they are rewritten.
- R10: During and right after reset, ready is high, no result or descriptor is raised, all configuration is zero, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | An instruction word is offered |
| instr_word_i | input | 32 | Instruction word |
| op_a_i | input | XLEN | First source register value |
| op_b_i | input | XLEN | Second source register value |
| instr_ready_o | output | 1 | Instruction is accepted this cycle |
| rd_valid_o | output | 1 | A register result is written this cycle |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | XLEN | Result value (ID or status) |
| desc_valid_o | output | 1 | Descriptor offered to the mover |
| desc_ready_i | input | 1 | Mover takes the descriptor |
| desc_src_o | output | 2*XLEN | Source address |
| desc_dst_o | output | 2*XLEN | Destination address |
| desc_size_o | output | XLEN | Bytes per row |
| desc_src_stride_o | output | XLEN | Source stride |
| desc_dst_stride_o | output | XLEN | Destination stride |
| desc_reps_o | output | XLEN | Row repeat count |
| desc_2d_o | output | 1 | Two-dimensional transfer |
| desc_id_o | output | XLEN | ID the transfer receives |
| xfer_done_i | input | 1 | One transfer finished, in issue order |

## Verification
The checks assume the mover pulses the completion input only while at least one transfer is outstanding. They also assume the instruction word and operands are held steady for as long as a copy stalls. The stimulus respects both: the bench raises a completion only when its own count of outstanding transfers is nonzero, and it drives every stalled copy with the same word and operands until the descriptor is taken. A behavioural model in the bench predicts every output in every cycle, including cycles where a status read and a completion coincide.

// File: rtl/dma_fe_pkg.sv
package dma_fe_pkg;
  localparam logic [6:0] DMA_OPCODE = 7'b0101011;
  localparam logic [2:0] DMA_FUNCT3 = 3'b000;
  localparam int unsigned CFG_2D_BIT = 1;
  localparam logic [4:0] STAT_SEL_DONE = 5'd0;
  localparam logic [4:0] STAT_SEL_BUSY = 5'd2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SRC,
    OP_DST,
    OP_COPY,
    OP_STAT,
    OP_STRIDE,
    OP_REPS
  } dma_op_e;
endpackage

// File: rtl/dma_fe_decode.sv
module dma_fe_decode
  import dma_fe_pkg::*;
(
  input  logic [31:0] word_i,
  output dma_op_e     op_o,
  output logic [4:0]  imm_o,
  output logic [4:0]  rd_o
);
  logic [6:0] funct7;
  logic       hit;

  assign funct7 = word_i[31:25];
  assign imm_o  = word_i[24:20];
  assign rd_o   = word_i[11:7];
  assign hit    = (word_i[6:0] == DMA_OPCODE) && (word_i[14:12] == DMA_FUNCT3);

  always_comb begin
    op_o = OP_NONE;
    if (hit) begin
      unique case (funct7)
        7'd0:    op_o = OP_SRC;
        7'd1:    op_o = OP_DST;
        7'd2:    op_o = OP_COPY;
        7'd4:    op_o = OP_STAT;
        7'd6:    op_o = OP_STRIDE;
        7'd7:    op_o = OP_REPS;
        default: op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dma_fe_cfg_regs.sv
module dma_fe_cfg_regs
  import dma_fe_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  dma_op_e           op_i,
  input  logic [XLEN-1:0]   op_a_i,
  input  logic [XLEN-1:0]   op_b_i,
  output logic [2*XLEN-1:0] src_o,
  output logic [2*XLEN-1:0] dst_o,
  output logic [XLEN-1:0]   src_stride_o,
  output logic [XLEN-1:0]   dst_stride_o,
  output logic [XLEN-1:0]   reps_o
);
  localparam int unsigned AW = 2 * XLEN;

  logic [AW-1:0]   src_q, src_d, dst_q, dst_d;
  logic [XLEN-1:0] sstr_q, sstr_d, dstr_q, dstr_d, reps_q, reps_d;
  logic            cfg_en;

  assign cfg_en = fire_i && (op_i inside {OP_SRC, OP_DST, OP_STRIDE, OP_REPS});

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    sstr_d = sstr_q;
    dstr_d = dstr_q;
    reps_d = reps_q;
    unique case (op_i)
      OP_SRC:    src_d = {op_b_i, op_a_i};
      OP_DST:    dst_d = {op_b_i, op_a_i};
      OP_STRIDE: begin
        sstr_d = op_a_i;
        dstr_d = op_b_i;
      end
      OP_REPS:   reps_d = op_a_i;
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      sstr_q <= '0;
      dstr_q <= '0;
      reps_q <= '0;
    end else if (cfg_en) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      sstr_q <= sstr_d;
      dstr_q <= dstr_d;
      reps_q <= reps_d;
    end
  end

  assign src_o        = src_q;
  assign dst_o        = dst_q;
  assign src_stride_o = sstr_q;
  assign dst_stride_o = dstr_q;
  assign reps_o       = reps_q;
endmodule

// File: rtl/dma_fe_id_track.sv
module dma_fe_id_track #(
  parameter int unsigned ID_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic            done_i,
  output logic [ID_W-1:0] next_id_o,
  output logic [ID_W-1:0] done_cnt_o,
  output logic            busy_o
);
  logic [ID_W-1:0] issued_q, issued_d, done_q, done_d;

  always_comb begin
    issued_d = issued_q + ID_W'(1);
    done_d   = done_q + ID_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issued_q <= '0;
    end else if (issue_i) begin
      issued_q <= issued_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
    end else if (done_i) begin
      done_q <= done_d;
    end
  end

  assign next_id_o  = issued_q;
  assign done_cnt_o = done_q;
  assign busy_o     = (issued_q != done_q);
endmodule

// File: rtl/dma_cmd_frontend.sv
module dma_cmd_frontend
  import dma_fe_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [31:0]       instr_word_i,
  input  logic [XLEN-1:0]   op_a_i,
  input  logic [XLEN-1:0]   op_b_i,
  output logic              instr_ready_o,
  output logic              rd_valid_o,
  output logic [4:0]        rd_idx_o,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [2*XLEN-1:0] desc_src_o,
  output logic [2*XLEN-1:0] desc_dst_o,
  output logic [XLEN-1:0]   desc_size_o,
  output logic [XLEN-1:0]   desc_src_stride_o,
  output logic [XLEN-1:0]   desc_dst_stride_o,
  output logic [XLEN-1:0]   desc_reps_o,
  output logic              desc_2d_o,
  output logic [XLEN-1:0]   desc_id_o,
  input  logic              xfer_done_i
);
  dma_op_e         op;
  logic [4:0]      imm;
  logic            fire;
  logic            issue;
  logic [XLEN-1:0] id_next;
  logic [XLEN-1:0] done_cnt;
  logic            busy;

  dma_fe_decode u_dec (
    .word_i (instr_word_i),
    .op_o   (op),
    .imm_o  (imm),
    .rd_o   (rd_idx_o)
  );

  assign desc_valid_o  = instr_valid_i && (op == OP_COPY);
  assign instr_ready_o = (op != OP_COPY) || desc_ready_i;
  assign fire          = instr_valid_i && instr_ready_o;
  assign issue         = desc_valid_o && desc_ready_i;

  dma_fe_cfg_regs #(.XLEN(XLEN)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .op_i         (op),
    .op_a_i       (op_a_i),
    .op_b_i       (op_b_i),
    .src_o        (desc_src_o),
    .dst_o        (desc_dst_o),
    .src_stride_o (desc_src_stride_o),
    .dst_stride_o (desc_dst_stride_o),
    .reps_o       (desc_reps_o)
  );

  dma_fe_id_track #(.ID_W(XLEN)) u_ids (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .done_i     (xfer_done_i),
    .next_id_o  (id_next),
    .done_cnt_o (done_cnt),
    .busy_o     (busy)
  );

  assign desc_size_o = op_a_i;
  assign desc_2d_o   = imm[CFG_2D_BIT];
  assign desc_id_o   = id_next;
  assign rd_valid_o  = fire && ((op == OP_COPY) || (op == OP_STAT));

  always_comb begin
    rd_data_o = '0;
    if (op == OP_COPY) begin
      rd_data_o = id_next;
    end else if (op == OP_STAT) begin
      if (imm == STAT_SEL_DONE)      rd_data_o = done_cnt;
      else if (imm == STAT_SEL_BUSY) rd_data_o = XLEN'(busy);
    end
  end
endmodule

// File: rtl/dma_fe_checker.sv
module dma_fe_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              instr_valid_i,
  input logic              instr_ready_o,
  input logic              rd_valid_o,
  input logic              desc_valid_o,
  input logic              desc_ready_i,
  input logic              xfer_done_i,
  input logic [2*XLEN-1:0] desc_src_o,
  input logic [2*XLEN-1:0] desc_dst_o,
  input logic [XLEN-1:0]   desc_reps_o,
  input logic [XLEN-1:0]   id_next,
  input logic [XLEN-1:0]   done_cnt
);
  assert_result_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (instr_valid_i && instr_ready_o));

  assert_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i) |-> (!instr_ready_o && !rd_valid_o));

  assert_id_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_ready_i) |=> (id_next == $past(id_next) + XLEN'(1)));

  assert_id_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(desc_valid_o && desc_ready_i) |=> $stable(id_next));

  assert_done_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> (done_cnt == $past(done_cnt) + XLEN'(1)));

  assert_cfg_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_ready_i) |=>
      ($stable(desc_src_o) && $stable(desc_dst_o) && $stable(desc_reps_o)));
endmodule

bind dma_cmd_frontend dma_fe_checker #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_ready_o (instr_ready_o),
  .rd_valid_o    (rd_valid_o),
  .desc_valid_o  (desc_valid_o),
  .desc_ready_i  (desc_ready_i),
  .xfer_done_i   (xfer_done_i),
  .desc_src_o    (desc_src_o),
  .desc_dst_o    (desc_dst_o),
  .desc_reps_o   (desc_reps_o),
  .id_next       (id_next),
  .done_cnt      (done_cnt)
);

// File: tb/dma_cmd_frontend_tb.sv
module dma_cmd_frontend_tb;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [XLEN-1:0] op_a = '0, op_b = '0;
  logic desc_ready = 1'b0, xfer_done = 1'b0;
  logic instr_ready, rd_valid, desc_valid, desc_2d;
  logic [4:0] rd_idx;
  logic [XLEN-1:0] rd_data, desc_size, desc_sstr, desc_dstr, desc_reps, desc_id;
  logic [2*XLEN-1:0] desc_src, desc_dst;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model state
  logic [63:0] m_src = '0, m_dst = '0;
  logic [31:0] m_sstr = '0, m_dstr = '0, m_reps = '0;
  int unsigned m_issued = 0, m_done = 0;

  always #10 clk = ~clk;

  dma_cmd_frontend #(.XLEN(XLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(instr_valid), .instr_word_i(instr_word),
    .op_a_i(op_a), .op_b_i(op_b),
    .instr_ready_o(instr_ready), .rd_valid_o(rd_valid), .rd_idx_o(rd_idx),
    .rd_data_o(rd_data), .desc_valid_o(desc_valid), .desc_ready_i(desc_ready),
    .desc_src_o(desc_src), .desc_dst_o(desc_dst), .desc_size_o(desc_size),
    .desc_src_stride_o(desc_sstr), .desc_dst_stride_o(desc_dstr),
    .desc_reps_o(desc_reps), .desc_2d_o(desc_2d), .desc_id_o(desc_id),
    .xfer_done_i(xfer_done)
  );

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] f_rs2,
                                      input logic [4:0] f_rd);
    return {f7, f_rs2, 5'd12, 3'b000, f_rd, 7'b0101011};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // one clock: drive, compare against the model, then update the model
  task automatic step(input string req, input logic v, input logic [31:0] w,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic dr, input logic dn);
    logic hit, e_ready, e_rdv, e_dv, fire;
    logic [6:0] f7;
    logic [4:0] sel;
    logic [31:0] e_rd;
    instr_valid = v; instr_word = w; op_a = a; op_b = b;
    desc_ready = dr; xfer_done = dn;
    #1;
    hit = (w[6:0] == 7'b0101011) && (w[14:12] == 3'b000);
    f7 = w[31:25];
    sel = w[24:20];
    if (hit && !(f7 inside {7'd0, 7'd1, 7'd2, 7'd4, 7'd6, 7'd7})) hit = 1'b0;
    e_dv = v && hit && (f7 == 7'd2);
    e_ready = !(hit && f7 == 7'd2) || dr;
    fire = v && e_ready;
    e_rdv = fire && hit && (f7 == 7'd2 || f7 == 7'd4);
    e_rd = '0;
    if (hit && f7 == 7'd2) e_rd = m_issued;
    if (hit && f7 == 7'd4) e_rd = (sel == 5'd0) ? m_done :
                                  (sel == 5'd2) ? 32'(m_issued != m_done) : 32'd0;
    chk(req, "instr_ready", 64'(instr_ready), 64'(e_ready));
    chk(req, "rd_valid", 64'(rd_valid), 64'(e_rdv));
    chk(req, "desc_valid", 64'(desc_valid), 64'(e_dv));
    if (e_rdv) begin
      chk(req, "rd_data", 64'(rd_data), 64'(e_rd));
      chk(req, "rd_idx", 64'(rd_idx), 64'(w[11:7]));
    end
    if (e_dv) begin
      chk(req, "desc_src", desc_src, m_src);
      chk(req, "desc_dst", desc_dst, m_dst);
      chk(req, "desc_size", 64'(desc_size), 64'(a));
      chk(req, "desc_sstr", 64'(desc_sstr), 64'(m_sstr));
      chk(req, "desc_dstr", 64'(desc_dstr), 64'(m_dstr));
      chk(req, "desc_reps", 64'(desc_reps), 64'(m_reps));
      chk(req, "desc_2d", 64'(desc_2d), 64'(w[21]));
      chk(req, "desc_id", 64'(desc_id), 64'(m_issued));
    end
    @(posedge clk);
    if (fire && hit) begin
      case (f7)
        7'd0: m_src = {b, a};
        7'd1: m_dst = {b, a};
        7'd6: begin m_sstr = a; m_dstr = b; end
        7'd7: m_reps = a;
        7'd2: m_issued++;
        default: ;
      endcase
    end
    if (dn) m_done++;
    @(negedge clk);
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    // R10: reset state while reset is held
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "ready in reset", 64'(instr_ready), 64'd1);
    chk("R10", "rd_valid in reset", 64'(rd_valid), 64'd0);
    chk("R10", "desc_valid in reset", 64'(desc_valid), 64'd0);
    chk("R10", "src in reset", desc_src, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 R8: counters zero after reset
    step("R10", 1'b1, enc(7'd4, 5'd0, 5'd5), 0, 0, 1'b1, 1'b0);
    step("R10", 1'b1, enc(7'd4, 5'd2, 5'd5), 0, 0, 1'b1, 1'b0);
    // R7 R5: first copy, 1D, gets ID 0 with zero config
    step("R7", 1'b1, enc(7'd2, 5'd0, 5'd10), 32'd16, 0, 1'b1, 1'b0);
    // R2: addresses, low from first operand, high from second
    step("R2", 1'b1, enc(7'd0, 5'd13, 5'd0), 32'h89AB_CDEF, 32'h0123_4567, 1'b1, 1'b0);
    step("R2", 1'b1, enc(7'd1, 5'd11, 5'd0), 32'h1000_0040, 32'h0000_0002, 1'b1, 1'b0);
    step("R8", 1'b1, enc(7'd4, 5'd2, 5'd6), 0, 0, 1'b1, 1'b0);
    // R3 R4: strides and repeat (second operand ignored on repeat)
    step("R3", 1'b1, enc(7'd6, 5'd15, 5'd0), 32'd64, 32'd128, 1'b1, 1'b0);
    step("R4", 1'b1, enc(7'd7, 5'd0, 5'd0), 32'd8, 32'hDEAD_BEEF, 1'b1, 1'b0);
    // R5: 2D copy
    step("R5", 1'b1, enc(7'd2, 5'b00010, 5'd10), 32'd32, 0, 1'b1, 1'b0);
    // R6: stall for two cycles then accept
    step("R6", 1'b1, enc(7'd2, 5'd0, 5'd10), 32'd4, 0, 1'b0, 1'b0);
    step("R6", 1'b1, enc(7'd2, 5'd0, 5'd10), 32'd4, 0, 1'b0, 1'b0);
    step("R6", 1'b1, enc(7'd2, 5'd0, 5'd10), 32'd4, 0, 1'b1, 1'b0);
    // R1: ignored words (bad opcode, bad funct3, unused funct7)
    step("R1", 1'b1, enc(7'd0, 5'd1, 5'd0) ^ 32'h0000_0004, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    step("R1", 1'b1, enc(7'd7, 5'd1, 5'd0) | 32'h0000_1000, 32'hFFFF_FFFF, 0, 1'b1, 1'b0);
    step("R1", 1'b1, enc(7'd3, 5'd1, 5'd3), 32'h5, 32'h5, 1'b1, 1'b0);
    step("R1", 1'b1, enc(7'd0, 5'd1, 5'd0), 32'h7, 32'h7, 1'b1, 1'b0) ;
    // R9: config reused; R1 check that src took the last legal write only
    step("R9", 1'b1, enc(7'd2, 5'd0, 5'd9), 32'd100, 0, 1'b1, 1'b0);
    // R8: completions, status reads, same-cycle read and pulse
    idle("R8");
    step("R8", 1'b0, 32'd0, 0, 0, 1'b1, 1'b1);
    step("R8", 1'b1, enc(7'd4, 5'd0, 5'd5), 0, 0, 1'b1, 1'b1);
    step("R8", 1'b1, enc(7'd4, 5'd0, 5'd5), 0, 0, 1'b1, 1'b1);
    step("R8", 1'b1, enc(7'd4, 5'd2, 5'd5), 0, 0, 1'b1, 1'b1);
    step("R8", 1'b1, enc(7'd4, 5'd2, 5'd5), 0, 0, 1'b1, 1'b0);
    step("R8", 1'b1, enc(7'd4, 5'd0, 5'd5), 0, 0, 1'b1, 1'b0);
    step("R8", 1'b1, enc(7'd4, 5'd1, 5'd5), 0, 0, 1'b1, 1'b0);
    // R7: IDs keep counting after completions
    step("R7", 1'b1, enc(7'd2, 5'b00010, 5'd7), 32'd8, 0, 1'b1, 1'b0);
    step("R7", 1'b1, enc(7'd4, 5'd2, 5'd5), 0, 0, 1'b1, 1'b0);
    idle("R7");
    summary();
    $finish;
  end
endmodule